// File: doc/BRIEF.md
# SMBus Timeout and Idle Monitor

This block watches the clock and data lines of a two-wire SMBus segment and checks them against the bus timing limits. It raises a flag when the clock has stayed low for longer than the detect limit. It tracks how long the local device itself stretches the clock and flags an overrun of the allowed extension. In slave mode the extension total covers a whole message. In master mode the total covers each byte segment.

It also reports a free bus once both lines have been high for long enough. A master that joins a bus already in use can therefore wait safely before its first transfer. The block produces one-cycle strobes for START, STOP and the acknowledge clock. All time limits are counted in ticks of the system clock. One parameter gives the number of ticks per millisecond, and every limit is derived from it.

The monitor only observes the lines. It does not drive them, shift bytes, decode addresses or compute packet error codes.

Top module: `smbus_timeout_mon`

## Requirements
- R1: `err_tlow` is set one cycle after the synchronized clock has been low for TLOW_MS milliseconds in a row. TLOW_MS is clamped into 25..35 and defaults to 25.
- R2: In slave mode (`mode_master`=0) the cycles with `hold_local`=1 are summed from the first START of a message to its STOP. `err_sext` is set when the sum exceeds 25 ms.
- R3: In master mode (`mode_master`=1) the cycles with `hold_local`=1 are summed per segment. Every START, acknowledge clock and STOP clears the sum. `err_mext` is set when one segment's sum exceeds 10 ms.
- R4: A repeated START does not clear the slave message sum, and it restarts bit counting from zero.
- R5: Clock-low time with `hold_local`=0 adds nothing to either extension sum.
- R6: `bus_idle` is 1 once both synchronized lines have been high for IDLE_TICKS cycles. It drops in the first cycle in which either synchronized line is low.
- R7: After the two-flop synchronizer, the strobes behave as follows, each one cycle long and never more than one at a time:
  - `start_p` fires when data falls while the clock is high.
  - `stop_p` fires when data rises while the clock is high.
  - `ack_p` fires on the 9th clock rise after a START and on every 9th rise after that.
- R8: Each error flag stays set until `clr` is pulsed. If a new violation and `clr` arrive in the same cycle, the flag is set.
- R9: While `rst_n`=0, all flags, `bus_idle` and all strobes are 0.
- R10: With `en`=0, all counters are held at zero, no flag is set, no strobe fires and `bus_idle` is 0.
- R11: The counters saturate. A clock-low period that has already set `err_tlow`, and is then cleared by `clr` while the clock stays low, does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Monitor enable |
| mode_master | input | 1 | 1 = local device is master, 0 = slave |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| hold_local | input | 1 | Local device is holding the clock low |
| clr | input | 1 | Clears the sticky error flags |
| err_tlow | output | 1 | Clock-low timeout flag |
| err_sext | output | 1 | Slave cumulative extension flag |
| err_mext | output | 1 | Master per-segment extension flag |
| bus_idle | output | 1 | Bus free level |
| start_p | output | 1 | START strobe |
| stop_p | output | 1 | STOP strobe |
| ack_p | output | 1 | Acknowledge clock strobe |

## Verification
The assertions assume the following about the inputs:
- Each bus line holds its level for at least three system cycles, so the synchronizer shows every edge and `bus_idle` follows the raw lines two cycles late.
- `hold_local` is asserted only while the clock line is low.
- `mode_master` is steady for the length of a message.

The stimulus drives every line level for four cycles or more and changes data only while the clock is low, except to form START, STOP and repeated START. It raises `hold_local` only inside clock-low phases and changes the mode only between messages.

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
  parameter int TICKS_PER_MS = 1000,
  parameter int TLOW_MS      = 25,
  parameter int SEXT_MS      = 25,
  parameter int MEXT_MS      = 10,
  parameter int IDLE_TICKS   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mode_master,
  input  logic scl_in,
  input  logic sda_in,
  input  logic hold_local,
  input  logic clr,
  output logic err_tlow,
  output logic err_sext,
  output logic err_mext,
  output logic bus_idle,
  output logic start_p,
  output logic stop_p,
  output logic ack_p
);
  localparam int TLOW_EFF = (TLOW_MS < 25) ? 25 : ((TLOW_MS > 35) ? 35 : TLOW_MS);
  localparam int TLOW_T = TLOW_EFF * TICKS_PER_MS;
  localparam int SEXT_T = SEXT_MS * TICKS_PER_MS;
  localparam int MEXT_T = MEXT_MS * TICKS_PER_MS;
  localparam int LW = $clog2(TLOW_T + 1);
  localparam int SW = $clog2(SEXT_T + 2);
  localparam int MW = $clog2(MEXT_T + 2);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam logic [LW-1:0] LOW_MAX  = LW'(TLOW_T);
  localparam logic [LW-1:0] LOW_LAST = LW'(TLOW_T - 1);
  localparam logic [SW-1:0] S_LIM    = SW'(SEXT_T);
  localparam logic [SW-1:0] S_MAX    = SW'(SEXT_T + 1);
  localparam logic [MW-1:0] M_LIM    = MW'(MEXT_T);
  localparam logic [MW-1:0] M_MAX    = MW'(MEXT_T + 1);
  localparam logic [IW-1:0] I_MAX    = IW'(IDLE_TICKS);

  logic scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q;
  logic in_msg;
  logic [3:0]    bitcnt;
  logic [LW-1:0] lowcnt;
  logic [SW-1:0] sacc;
  logic [MW-1:0] macc;
  logic [IW-1:0] idlecnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q} <= '1;
    else begin
      scl_s1 <= scl_in; scl_s2 <= scl_s1; scl_q <= scl_s2;
      sda_s1 <= sda_in; sda_s2 <= sda_s1; sda_q <= sda_s2;
    end

  wire scl_rise = scl_s2 & ~scl_q;
  wire scl_hi   = scl_s2 & scl_q;
  assign start_p = en & scl_hi & sda_q & ~sda_s2;
  assign stop_p  = en & scl_hi & ~sda_q & sda_s2;
  assign ack_p   = en & in_msg & scl_rise & (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_msg <= 1'b0;
      bitcnt <= '0;
    end else if (!en) begin
      in_msg <= 1'b0;
      bitcnt <= '0;
    end else if (start_p) begin
      in_msg <= 1'b1;
      bitcnt <= '0;
    end else if (stop_p) begin
      in_msg <= 1'b0;
    end else if (in_msg && scl_rise) begin
      bitcnt <= (bitcnt == 4'd8) ? 4'd0 : bitcnt + 4'd1;
    end

  wire low_hit = en & ~scl_s2 & (lowcnt == LOW_LAST);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 lowcnt <= '0;
    else if (!en || scl_s2)     lowcnt <= '0;
    else if (lowcnt != LOW_MAX) lowcnt <= lowcnt + LW'(1);

  wire s_clr = ~en | mode_master | stop_p | (start_p & ~in_msg);
  wire s_inc = in_msg & hold_local & ~s_clr;
  wire s_hit = s_inc & (sacc == S_LIM);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      sacc <= '0;
    else if (s_clr)                  sacc <= '0;
    else if (s_inc && sacc != S_MAX) sacc <= sacc + SW'(1);

  wire m_clr = ~en | ~mode_master | start_p | stop_p | ack_p;
  wire m_inc = in_msg & hold_local & ~m_clr;
  wire m_hit = m_inc & (macc == M_LIM);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      macc <= '0;
    else if (m_clr)                  macc <= '0;
    else if (m_inc && macc != M_MAX) macc <= macc + MW'(1);

  wire both_hi = en & scl_s2 & sda_s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  idlecnt <= '0;
    else if (!both_hi)           idlecnt <= '0;
    else if (idlecnt != I_MAX)   idlecnt <= idlecnt + IW'(1);
  assign bus_idle = both_hi & (idlecnt == I_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {err_tlow, err_sext, err_mext} <= '0;
    else begin
      err_tlow <= (err_tlow & ~clr) | low_hit;
      err_sext <= (err_sext & ~clr) | s_hit;
      err_mext <= (err_mext & ~clr) | m_hit;
    end
endmodule

// File: rtl/smbus_timeout_mon_chk.sv
module smbus_timeout_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mode_master,
  input logic scl_in,
  input logic sda_in,
  input logic clr,
  input logic err_tlow,
  input logic err_sext,
  input logic err_mext,
  input logic bus_idle,
  input logic start_p,
  input logic stop_p,
  input logic ack_p
);
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, stop_p, ack_p}));
  assert_tlow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tlow && !clr) |=> err_tlow);
  assert_sext_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sext && !clr) |=> err_sext);
  assert_mext_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mext && !clr) |=> err_mext);
  assert_idle_lines_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> ($past(scl_in, 2) && $past(sda_in, 2)));
  assert_mext_in_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mext) |-> $past(mode_master));
  assert_sext_in_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sext) |-> !$past(mode_master));
  assert_no_new_flag_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !err_tlow) |=> !err_tlow);
endmodule

bind smbus_timeout_mon smbus_timeout_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode_master(mode_master),
  .scl_in(scl_in), .sda_in(sda_in), .clr(clr),
  .err_tlow(err_tlow), .err_sext(err_sext), .err_mext(err_mext),
  .bus_idle(bus_idle), .start_p(start_p), .stop_p(stop_p), .ack_p(ack_p)
);

// File: tb/smbus_timeout_mon_bench.sv
`timescale 1ns/1ps
module smbus_timeout_mon_bench;
  logic clk = 0, rst_n = 0, en = 1, mode_master = 0;
  logic scl_in = 1, sda_in = 1, hold_local = 0, clr = 0;
  logic err_tlow, err_sext, err_mext, bus_idle, start_p, stop_p, ack_p;
  int checks = 0, fails = 0;
  int nstart = 0, nstop = 0, nack = 0;

  always #2.5 clk = ~clk;

  smbus_timeout_mon #(.TICKS_PER_MS(4), .IDLE_TICKS(20)) u_smbus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_master(mode_master),
    .scl_in(scl_in), .sda_in(sda_in), .hold_local(hold_local), .clr(clr),
    .err_tlow(err_tlow), .err_sext(err_sext), .err_mext(err_mext),
    .bus_idle(bus_idle), .start_p(start_p), .stop_p(stop_p), .ack_p(ack_p));

  always @(posedge clk) begin
    if (start_p) nstart++;
    if (stop_p)  nstop++;
    if (ack_p)   nack++;
  end

  // {scl, sda, hold, cycles[7:0], exp idle, tlow, sext, mext}
  localparam logic [14:0] VEC [10] = '{
    {3'b110, 8'd30,  4'b1000},
    {3'b100, 8'd4,   4'b0000},
    {3'b001, 8'd60,  4'b0000},
    {3'b100, 8'd4,   4'b0000},
    {3'b001, 8'd50,  4'b0010},
    {3'b100, 8'd4,   4'b0010},
    {3'b110, 8'd4,   4'b0010},
    {3'b110, 8'd30,  4'b1010},
    {3'b010, 8'd120, 4'b0110},
    {3'b110, 8'd30,  4'b1110}
  };

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic chk_n(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic phase(input logic c, input logic d, input logic h, input int n);
    scl_in = c; sda_in = d; hold_local = h;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();  phase(1, 1, 0, 4); phase(1, 0, 0, 4); endtask
  task automatic do_stop();   phase(0, 0, 0, 4); phase(1, 0, 0, 4); phase(1, 1, 0, 4); endtask
  task automatic do_bit(input int low, input logic h);
    phase(0, 0, h, low); phase(1, 0, 0, 4);
  endtask
  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0; @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    chk(err_tlow, 0, "R9 reset err_tlow");
    chk(err_sext, 0, "R9 reset err_sext");
    chk(err_mext, 0, "R9 reset err_mext");
    chk(bus_idle | start_p | stop_p | ack_p, 0, "R9 reset idle/strobes");
    rst_n = 1;

    for (int i = 0; i < 10; i++) begin
      phase(VEC[i][14], VEC[i][13], VEC[i][12], int'(VEC[i][11:4]));
      chk(bus_idle, VEC[i][3], $sformatf("R6 vec %0d bus_idle", i));
      chk(err_tlow, VEC[i][2], $sformatf("R1 vec %0d err_tlow", i));
      chk(err_sext, VEC[i][1], $sformatf("R2 vec %0d err_sext", i));
      chk(err_mext, VEC[i][0], $sformatf("R3 vec %0d err_mext", i));
    end
    chk_n(nstart, 1, "R7 start count");
    chk_n(nstop, 1, "R7 stop count");
    chk_n(nack, 0, "R7 ack count");

    pulse_clr();
    chk(err_tlow | err_sext | err_mext, 0, "R8 clr clears flags");

    // R1 boundary
    phase(0, 1, 0, 95); phase(1, 1, 0, 10);
    chk(err_tlow, 0, "R1 low 95 below limit");
    phase(0, 1, 0, 105);
    chk(err_tlow, 1, "R1 low 105 over limit");
    // R11 clear while still low, no re-trigger
    clr = 1; @(negedge clk); clr = 0;
    phase(0, 1, 0, 60);
    chk(err_tlow, 0, "R11 no re-trigger while low");
    phase(1, 1, 0, 30);

    // R5 foreign stretch, slave mode
    mode_master = 0;
    do_start(); do_bit(90, 0); do_bit(90, 0); do_stop();
    chk(err_sext, 0, "R5 foreign stretch ignored");
    chk(err_tlow, 0, "R5 no tlow at 90");

    // R4 repeated start, slave mode
    nack = 0;
    do_start(); do_bit(60, 1);
    for (int b = 0; b < 4; b++) do_bit(4, 0);
    phase(0, 1, 0, 4); phase(1, 1, 0, 4); phase(1, 0, 0, 4);
    chk_n(nack, 0, "R4 no ack before rest");
    do_bit(50, 1);
    chk(err_sext, 1, "R4 sum kept across repeated start");
    do_bit(4, 0); do_bit(4, 0);
    chk_n(nack, 0, "R4 bit count restarted");
    for (int b = 0; b < 6; b++) do_bit(4, 0);
    chk_n(nack, 1, "R7 ack on 9th rise");
    do_stop();
    pulse_clr();

    // R3 master per segment
    mode_master = 1; nack = 0;
    do_start(); do_bit(30, 1);
    for (int b = 0; b < 8; b++) do_bit(4, 0);
    chk_n(nack, 1, "R3 ack after byte");
    do_bit(30, 1);
    chk(err_mext, 0, "R3 sum cleared at ack");
    do_bit(20, 1);
    chk(err_mext, 1, "R3 segment over 10ms");
    chk(err_sext, 0, "R2 no slave flag in master mode");
    for (int b = 0; b < 7; b++) do_bit(4, 0);
    do_stop();
    phase(1, 1, 0, 30);

    // R8 sticky through idle, then clear
    chk(err_mext, 1, "R8 mext sticky");
    pulse_clr();
    chk(err_mext, 0, "R8 mext cleared");

    // R10 disabled
    en = 0; a0 = nstart;
    phase(1, 1, 0, 30);
    chk(bus_idle, 0, "R10 idle off when disabled");
    phase(1, 0, 0, 4);
    chk_n(nstart, a0, "R10 no start strobe");
    phase(0, 0, 0, 150);
    chk(err_tlow, 0, "R10 no tlow when disabled");
    phase(1, 1, 0, 10);
    en = 1;
    phase(1, 1, 0, 30);
    chk(bus_idle, 1, "R6 idle after enable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule